// File: doc/BRIEF.md
# Unfused Floating-Point Multiply-Add Unit

This unit evaluates `fs × ft + fr` on IEEE-754 single-precision values. It works in two separately rounded steps. First it forms the product of `fs` and `ft` and rounds it to single precision. Then it adds `fr` to that rounded product and rounds the exact sum again. Both steps use the same rounding mode. The results and exception conditions are therefore the same as those of a standalone multiply followed by a standalone add. Any condition raised by the multiply step stays visible even when the add step would hide it.

A paired mode packs two 32-bit lanes into each 64-bit operand. The two lanes compute independently, each into its own half of the result, and their exception conditions are ORed into one cause vector. A cause vector is produced for every operation. A trap is signalled when an enabled condition is present. The sticky flag register absorbs the cause bits only when no trap is taken.

The unit is a small sequencer with four states: idle, multiply, add and done. A start strobe seen while idle captures the operands. The outputs are registered and become valid together with a one-cycle done strobe.

Top module: `madd_unit`

## Requirements
- R1: With mode code 0, the low 32 bits of the result equal the round-to-nearest-even of (round(fs×ft) + fr), where fs and ft are the multiplicands and fr is the addend. Example: 2·3+1 gives 0x40E00000.
- R2: The rounding-mode input applies to both steps with this encoding: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward −infinity.
- R3: Conditions raised by the multiply step appear in the cause bits even when the add result is exact. The add operates on the already-rounded product.
- R4: Format code 1 selects paired mode: the lanes at bits 31:0 and 63:32 compute independently and their causes are ORed. Format code 0 uses only bits 31:0, and result bits 63:32 read zero.
- R5: Each of these raises invalid: infinity×zero in the multiply, infinities of opposite sign in the add, and any signaling NaN input (exponent all ones, fraction nonzero, fraction bit 22 clear). Every NaN result is 0x7FC00000, and a quiet NaN input raises nothing.
- R6: On overflow, a step sets overflow and inexact. It returns infinity under mode 0, under mode 2 for a positive result, and under mode 3 for a negative result; otherwise it returns the largest finite value. A tiny result becomes a signed zero with underflow and inexact set. Inputs with a zero exponent count as zero.
- R7: The cause bits are bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 invalid and bit 4 unimplemented. A trap is taken when any of bits 3:0 is set together with the matching bit of the 4-bit enable. Format codes 2 and 3 give cause 0x10, a zero result and a trap regardless of the enable.
- R8: When no trap is taken, the sticky flags become the old flags OR the cause bits. When a trap is taken they keep their value. Reset clears them.
- R9: The done strobe goes high for exactly one cycle, on the third clock edge after an accepted start. A start seen while busy is ignored. After reset, done, trap, cause, flags and result are all zero.
- R10: An exactly-zero sum of nonzero terms is +0, except under mode 3, where it is −0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| fmt_i | input | 2 | Format: 0 single, 1 paired, other codes unimplemented |
| rm_i | input | 2 | Rounding mode |
| en_i | input | 4 | Trap enables for cause bits 3:0 |
| fs_i | input | 64 | Multiplicand |
| ft_i | input | 64 | Multiplier |
| fr_i | input | 64 | Addend |
| done_o | output | 1 | One-cycle completion strobe |
| res_o | output | 64 | Result |
| cause_o | output | 5 | Conditions raised by the operation |
| flags_o | output | 5 | Sticky flags |
| trap_o | output | 1 | Trap taken for this operation |

## Verification
A wrong product register shows up as a wrong result on the done cycle of the same operation, three edges after start. The cases that expose it are the ones where fused and unfused answers differ: an inexact product followed by a cancelling add. A flaw in the sequencer shows as a done strobe that is missing, early or longer than one cycle. A corrupted sticky-flag register persists, so a single wrong update is visible on every later done cycle, and the bench compares the flags after each operation. Errors in lane masking appear as nonzero upper result bits in single mode, or as missing lane causes in paired mode.

// File: rtl/madd_pkg.sv
// madd_pkg: shared types and arithmetic helpers for the multiply-add unit.
// Assumes single-precision lanes; denormals are treated as zero throughout.
package madd_pkg;

    localparam int LANE_W = 32;
    localparam logic [31:0] QNAN = 32'h7FC00000;
    localparam logic [1:0] FMT_SGL  = 2'd0;
    localparam logic [1:0] FMT_PAIR = 2'd1;

    typedef enum logic [1:0] {RM_NE = 2'd0, RM_TZ = 2'd1, RM_UP = 2'd2, RM_DN = 2'd3} rmode_e;
    typedef enum logic [1:0] {S_IDLE, S_MUL, S_ADD, S_DONE} st_e;

    // bit4 unimplemented, bit3 invalid, bit2 overflow, bit1 underflow, bit0 inexact
    typedef struct packed {
        logic unimpl;
        logic invalid;
        logic ovf;
        logic unf;
        logic inexact;
    } exc_t;

    typedef struct packed {
        logic [31:0] val;
        exc_t        exc;
    } rres_t;

    // Round a normalized mantissa with guard/sticky, then pack with range checks.
    function automatic rres_t round_pack(input logic sgn, input logic signed [10:0] exp_in,
                                        input logic [23:0] man, input logic g, input logic s,
                                        input rmode_e rm);
        rres_t r;
        logic up, to_inf;
        logic [24:0] sum;
        logic signed [10:0] e2;
        r = '0;
        case (rm)
            RM_NE:   up = g & (s | man[0]);
            RM_TZ:   up = 1'b0;
            RM_UP:   up = ~sgn & (g | s);
            default: up = sgn & (g | s);
        endcase
        sum = {1'b0, man} + {24'd0, up};
        e2  = exp_in + $signed({10'd0, sum[24]});
        r.exc.inexact = g | s;
        to_inf = (rm == RM_NE) | ((rm == RM_UP) & ~sgn) | ((rm == RM_DN) & sgn);
        if (e2 >= 11'sd255) begin
            r.exc.ovf = 1'b1;
            r.exc.inexact = 1'b1;
            r.val = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
        end else if (e2 <= 11'sd0) begin
            r.exc.unf = 1'b1;
            r.exc.inexact = 1'b1;
            r.val = {sgn, 31'd0};
        end else begin
            r.val = {sgn, e2[7:0], sum[24] ? 23'd0 : sum[22:0]};
        end
        return r;
    endfunction

    // Leading-zero count of a 27-bit vector (27 when all zero).
    function automatic logic [4:0] lzc27(input logic [26:0] v);
        logic [4:0] n;
        n = 5'd27;
        for (int i = 0; i < 27; i++) begin
            if (v[i]) n = 5'(26 - i);
        end
        return n;
    endfunction

endpackage

// File: rtl/madd_mul.sv
// madd_mul: combinational single-precision multiply with one rounding.
// Assumes zero-exponent inputs are zero; every NaN output is canonical.
module madd_mul
    import madd_pkg::*;
(
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  rmode_e      rm_i,
    output logic [31:0] p_o,
    output exc_t        exc_o
);
    logic za, zb, ia, ib, na, nb, sgn;
    logic [47:0] prod;
    logic signed [10:0] e;
    rres_t r;

    // Classify operands and produce the rounded product.
    always_comb begin
        za  = (a_i[30:23] == 8'd0);
        zb  = (b_i[30:23] == 8'd0);
        ia  = (a_i[30:23] == 8'hFF) & (a_i[22:0] == 23'd0);
        ib  = (b_i[30:23] == 8'hFF) & (b_i[22:0] == 23'd0);
        na  = (a_i[30:23] == 8'hFF) & (a_i[22:0] != 23'd0);
        nb  = (b_i[30:23] == 8'hFF) & (b_i[22:0] != 23'd0);
        sgn = a_i[31] ^ b_i[31];
        prod = {1'b1, a_i[22:0]} * {1'b1, b_i[22:0]};
        e = $signed({3'd0, a_i[30:23]}) + $signed({3'd0, b_i[30:23]}) - 11'sd127;
        r = prod[47] ? round_pack(sgn, e + 11'sd1, prod[47:24], prod[23], |prod[22:0], rm_i)
                     : round_pack(sgn, e, prod[46:23], prod[22], |prod[21:0], rm_i);
        exc_o = '0;
        if (na | nb) begin
            p_o = QNAN;
            exc_o.invalid = (na & ~a_i[22]) | (nb & ~b_i[22]);
        end else if ((ia & zb) | (za & ib)) begin
            p_o = QNAN;
            exc_o.invalid = 1'b1;
        end else if (ia | ib) begin
            p_o = {sgn, 8'hFF, 23'd0};
        end else if (za | zb) begin
            p_o = {sgn, 31'd0};
        end else begin
            p_o = r.val;
            exc_o = r.exc;
        end
    end
endmodule

// File: rtl/madd_add.sv
// madd_add: combinational single-precision add, exact sum then one rounding.
// Assumes zero-exponent inputs are zero; uses guard/round/sticky alignment.
module madd_add
    import madd_pkg::*;
(
    input  logic [31:0] a_i,
    input  logic [31:0] c_i,
    input  rmode_e      rm_i,
    output logic [31:0] s_o,
    output exc_t        exc_o
);
    logic za, zc, ia, ic, na, nc;
    logic [31:0] big, sml;
    logic [7:0]  d;
    logic [4:0]  dcl, lz;
    logic [55:0] sm56;
    logic [27:0] big28, sm28, sum, nrm;
    rres_t r;

    // Align the smaller magnitude, add or subtract, normalize, round.
    always_comb begin
        za = (a_i[30:23] == 8'd0);
        zc = (c_i[30:23] == 8'd0);
        ia = (a_i[30:23] == 8'hFF) & (a_i[22:0] == 23'd0);
        ic = (c_i[30:23] == 8'hFF) & (c_i[22:0] == 23'd0);
        na = (a_i[30:23] == 8'hFF) & (a_i[22:0] != 23'd0);
        nc = (c_i[30:23] == 8'hFF) & (c_i[22:0] != 23'd0);
        if (a_i[30:0] >= c_i[30:0]) begin big = a_i; sml = c_i; end
        else                        begin big = c_i; sml = a_i; end
        d     = big[30:23] - sml[30:23];
        dcl   = (d > 8'd28) ? 5'd28 : d[4:0];
        sm56  = {2'b01, sml[22:0], 31'd0} >> dcl;
        sm28  = sm56[55:28] | {27'd0, |sm56[27:0]};
        big28 = {2'b01, big[22:0], 3'd0};
        sum   = (a_i[31] ^ c_i[31]) ? big28 - sm28 : big28 + sm28;
        lz    = lzc27(sum[26:0]);
        nrm   = sum << lz;
        r = sum[27] ? round_pack(big[31], $signed({3'd0, big[30:23]}) + 11'sd1,
                                 sum[27:4], sum[3], |sum[2:0], rm_i)
                    : round_pack(big[31], $signed({3'd0, big[30:23]}) - $signed({6'd0, lz}),
                                 nrm[26:3], nrm[2], |nrm[1:0], rm_i);
        exc_o = '0;
        if (na | nc) begin
            s_o = QNAN;
            exc_o.invalid = (na & ~a_i[22]) | (nc & ~c_i[22]);
        end else if (ia & ic & (a_i[31] != c_i[31])) begin
            s_o = QNAN;
            exc_o.invalid = 1'b1;
        end else if (ia) begin
            s_o = a_i;
        end else if (ic) begin
            s_o = c_i;
        end else if (za & zc) begin
            s_o = {(a_i[31] == c_i[31]) ? a_i[31] : (rm_i == RM_DN), 31'd0};
        end else if (za) begin
            s_o = c_i;
        end else if (zc) begin
            s_o = a_i;
        end else if (sum == 28'd0) begin
            s_o = {(rm_i == RM_DN), 31'd0};
        end else begin
            s_o = r.val;
            exc_o = r.exc;
        end
    end
endmodule

// File: rtl/madd_unit.sv
// madd_unit: sequenced unfused multiply-add over NLANE single-precision lanes.
// Assumes start is a strobe; operands are captured only while idle.
module madd_unit
    import madd_pkg::*;
#(
    parameter int NLANE = 2
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [1:0]              fmt_i,
    input  logic [1:0]              rm_i,
    input  logic [3:0]              en_i,
    input  logic [NLANE*LANE_W-1:0] fs_i,
    input  logic [NLANE*LANE_W-1:0] ft_i,
    input  logic [NLANE*LANE_W-1:0] fr_i,
    output logic                    done_o,
    output logic [NLANE*LANE_W-1:0] res_o,
    output logic [4:0]              cause_o,
    output logic [4:0]              flags_o,
    output logic                    trap_o
);
    localparam int OPW = NLANE * LANE_W;

    st_e st;
    logic [OPW-1:0] fs_q, ft_q, fr_q, res_c;
    logic [1:0] fmt_q;
    rmode_e     rm_q;
    logic [3:0] en_q;
    logic [4:0] cause_c;
    logic       trap_c;
    logic [LANE_W-1:0] lane_res [NLANE];
    exc_t              lane_exc [NLANE];

    // Sequencer: idle -> multiply -> add -> done -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else case (st)
            S_IDLE:  if (start_i) st <= S_MUL;
            S_MUL:   st <= S_ADD;
            S_ADD:   st <= S_DONE;
            default: st <= S_IDLE;
        endcase
    end

    // Operand capture on an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0; ft_q <= '0; fr_q <= '0;
            fmt_q <= FMT_SGL; rm_q <= RM_NE; en_q <= '0;
        end else if (st == S_IDLE && start_i) begin
            fs_q <= fs_i; ft_q <= ft_i; fr_q <= fr_i;
            fmt_q <= fmt_i; rm_q <= rmode_e'(rm_i); en_q <= en_i;
        end
    end

    for (genvar gi = 0; gi < NLANE; gi++) begin : g_lane
        logic [LANE_W-1:0] prod_w, prod_q;
        exc_t pexc_w, pexc_q, aexc_w;

        madd_mul u_mul (.a_i(fs_q[gi*LANE_W +: LANE_W]), .b_i(ft_q[gi*LANE_W +: LANE_W]),
                        .rm_i(rm_q), .p_o(prod_w), .exc_o(pexc_w));

        // Hold the rounded product and its conditions for the add step.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q <= '0; pexc_q <= '0;
            end else if (st == S_MUL) begin
                prod_q <= prod_w; pexc_q <= pexc_w;
            end
        end

        madd_add u_add (.a_i(prod_q), .c_i(fr_q[gi*LANE_W +: LANE_W]), .rm_i(rm_q),
                        .s_o(lane_res[gi]), .exc_o(aexc_w));

        assign lane_exc[gi] = exc_t'(pexc_q | aexc_w);
    end

    // Merge active lanes, handle unimplemented formats, decide the trap.
    always_comb begin
        cause_c = '0;
        res_c   = '0;
        for (int g = 0; g < NLANE; g++) begin
            if (g == 0 || fmt_q == FMT_PAIR) begin
                cause_c = cause_c | lane_exc[g];
                res_c[g*LANE_W +: LANE_W] = lane_res[g];
            end
        end
        if (fmt_q != FMT_SGL && fmt_q != FMT_PAIR) begin
            res_c   = '0;
            cause_c = 5'b10000;
        end
        trap_c = cause_c[4] | (|(cause_c[3:0] & en_q));
    end

    // Output registers and sticky flags, updated as the add step completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o <= '0; cause_o <= '0; trap_o <= 1'b0; flags_o <= '0;
        end else if (st == S_ADD) begin
            res_o   <= res_c;
            cause_o <= cause_c;
            trap_o  <= trap_c;
            if (!trap_c) flags_o <= flags_o | cause_c;
        end
    end

    assign done_o = (st == S_DONE);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o);
    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(st == S_IDLE && start_i, 3));
    // R8
    flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & $past(flags_o)) == $past(flags_o));
    // R8
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && trap_o) |-> flags_o == $past(flags_o));
    // R7
    unimpl_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cause_o[4]) |-> trap_o);
    // R5
    nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fmt_q == FMT_SGL && cause_o[3]) |-> res_o[31:0] == QNAN);
    // R4
    single_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fmt_q == FMT_SGL) |-> res_o[OPW-1:LANE_W] == '0);
endmodule

// File: tb/sim_madd_unit.sv
`timescale 1ns/1ps
module sim_madd_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic [1:0]  rm_i = 2'd0;
    logic [3:0]  en_i = 4'd0;
    logic [63:0] fs_i = '0, ft_i = '0, fr_i = '0;
    logic        done_o, trap_o;
    logic [63:0] res_o;
    logic [4:0]  cause_o, flags_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] exp_flags = '0;
    logic [3:0] en_cur = '0;

    always #2 clk = ~clk;

    madd_unit u0 (.clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_i(fmt_i), .rm_i(rm_i),
                  .en_i(en_i), .fs_i(fs_i), .ft_i(ft_i), .fr_i(fr_i), .done_o(done_o),
                  .res_o(res_o), .cause_o(cause_o), .flags_o(flags_o), .trap_o(trap_o));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Start one operation and wait for done; checks the latency (R9).
    task automatic run_op(input logic [1:0] fmt, input logic [1:0] rm, input logic [3:0] en,
                          input logic [63:0] fs, input logic [63:0] ft, input logic [63:0] fr);
        int n;
        @(negedge clk);
        fmt_i = fmt; rm_i = rm; en_i = en; en_cur = en;
        fs_i = fs; ft_i = ft; fr_i = fr; start_i = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            start_i = 1'b0;
            n++;
        end while (!done_o && n < 8);
        chk("R9 latency", 64'(n), 64'd3);
    endtask

    // Compare outputs against expectations and track the sticky flags (R7, R8).
    task automatic expect_out(input string tag, input logic [63:0] eres, input logic [4:0] ecause);
        logic etrap;
        etrap = ecause[4] | (|(ecause[3:0] & en_cur));
        if (!etrap) exp_flags = exp_flags | ecause;
        chk({tag, " result"}, res_o, eres);
        chk({tag, " cause"}, 64'(cause_o), 64'(ecause));
        chk({tag, " R7 trap"}, 64'(trap_o), 64'(etrap));
        chk({tag, " R8 flags"}, 64'(flags_o), 64'(exp_flags));
    endtask

    task automatic t_reset;
        chk("R9 reset done", 64'(done_o), 64'd0);
        chk("R9 reset result", res_o, 64'd0);
        chk("R9 reset cause", 64'(cause_o), 64'd0);
        chk("R8 reset flags", 64'(flags_o), 64'd0);
        chk("R9 reset trap", 64'(trap_o), 64'd0);
    endtask

    task automatic t_basic;
        run_op(2'd0, 2'd0, 4'd0, {32'hDEADBEEF, 32'h40000000}, {32'h12345678, 32'h40400000},
               {32'hCAFEF00D, 32'h3F800000});
        expect_out("R1 R4 2*3+1", 64'h40E00000, 5'h00);
        run_op(2'd0, 2'd0, 4'd0, 64'h3FC00000, 64'h3FC00000, 64'h3F000000);
        expect_out("R1 1.5*1.5+0.5", 64'h40300000, 5'h00);
    endtask

    task automatic t_round;
        run_op(2'd0, 2'd0, 4'd0, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R2 R3 near", 64'h3F800002, 5'h01);
        run_op(2'd0, 2'd1, 4'd0, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R2 zero", 64'h3F800002, 5'h01);
        run_op(2'd0, 2'd2, 4'd0, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R2 up", 64'h3F800003, 5'h01);
        run_op(2'd0, 2'd3, 4'd0, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R2 down", 64'h3F800002, 5'h01);
        run_op(2'd0, 2'd0, 4'd0, 64'h3F800001, 64'h3F800001, 64'hBF800000);
        expect_out("R1 R3 unfused cancel", 64'h34800000, 5'h01);
        run_op(2'd0, 2'd2, 4'd0, 64'h3F800001, 64'h3F800001, 64'hBF800000);
        expect_out("R2 R3 cancel up", 64'h34C00000, 5'h01);
    endtask

    task automatic t_overflow;
        run_op(2'd0, 2'd0, 4'd0, 64'h7F000000, 64'h40000000, 64'h3F800000);
        expect_out("R6 R3 ovf near", 64'h7F800000, 5'h05);
        run_op(2'd0, 2'd1, 4'd0, 64'h7F000000, 64'h40000000, 64'h3F800000);
        expect_out("R6 ovf zero", 64'h7F7FFFFF, 5'h05);
        run_op(2'd0, 2'd2, 4'd0, 64'h7F000000, 64'h40000000, 64'h3F800000);
        expect_out("R6 ovf up", 64'h7F800000, 5'h05);
        run_op(2'd0, 2'd3, 4'd0, 64'h7F000000, 64'h40000000, 64'h3F800000);
        expect_out("R6 ovf down", 64'h7F7FFFFF, 5'h05);
    endtask

    task automatic t_tiny;
        run_op(2'd0, 2'd0, 4'd0, 64'h00800000, 64'h3F000000, 64'h0);
        expect_out("R6 underflow", 64'h0, 5'h03);
        run_op(2'd0, 2'd0, 4'd0, 64'h00000001, 64'h40000000, 64'h3F800000);
        expect_out("R6 denormal in", 64'h3F800000, 5'h00);
    endtask

    task automatic t_invalid;
        run_op(2'd0, 2'd0, 4'd0, 64'h7F800000, 64'h0, 64'h3F800000);
        expect_out("R5 inf*0", 64'h7FC00000, 5'h08);
        run_op(2'd0, 2'd0, 4'd0, 64'h7F800000, 64'h3F800000, 64'hFF800000);
        expect_out("R5 inf-inf", 64'h7FC00000, 5'h08);
        run_op(2'd0, 2'd0, 4'd0, 64'h3F800000, 64'h3F800000, 64'h7F800001);
        expect_out("R5 snan", 64'h7FC00000, 5'h08);
        run_op(2'd0, 2'd0, 4'd0, 64'h3F800000, 64'h3F800000, 64'h7FC00001);
        expect_out("R5 qnan", 64'h7FC00000, 5'h00);
    endtask

    task automatic t_zero_sign;
        run_op(2'd0, 2'd0, 4'd0, 64'h3F800000, 64'h3F800000, 64'hBF800000);
        expect_out("R10 +0", 64'h00000000, 5'h00);
        run_op(2'd0, 2'd3, 4'd0, 64'h3F800000, 64'h3F800000, 64'hBF800000);
        expect_out("R10 -0", 64'h80000000, 5'h00);
    endtask

    task automatic t_paired;
        run_op(2'd1, 2'd0, 4'd0, {32'h40000000, 32'h7F000000}, {32'h40400000, 32'h40000000},
               {32'h3F800000, 32'h3F800000});
        expect_out("R4 paired", {32'h40E00000, 32'h7F800000}, 5'h05);
    endtask

    task automatic t_unimpl;
        run_op(2'd2, 2'd0, 4'd0, 64'h40000000, 64'h40000000, 64'h0);
        expect_out("R7 fmt2", 64'h0, 5'h10);
        run_op(2'd3, 2'd0, 4'd0, 64'h40000000, 64'h40000000, 64'h0);
        expect_out("R7 fmt3", 64'h0, 5'h10);
    endtask

    task automatic t_trap;
        run_op(2'd0, 2'd0, 4'b0001, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R8 trapped inexact", 64'h3F800002, 5'h01);
        run_op(2'd0, 2'd0, 4'b0100, 64'h7F000000, 64'h40000000, 64'h0);
        expect_out("R7 trapped ovf", 64'h7F800000, 5'h05);
        run_op(2'd0, 2'd0, 4'b1000, 64'h3F800001, 64'h3F800001, 64'h0);
        expect_out("R7 masked inexact", 64'h3F800002, 5'h01);
    endtask

    // Start held high while busy must not launch a second operation (R9).
    task automatic t_busy;
        int seen;
        @(negedge clk);
        fmt_i = 2'd0; rm_i = 2'd0; en_i = 4'd0; en_cur = 4'd0;
        fs_i = 64'h40000000; ft_i = 64'h40400000; fr_i = 64'h3F800000; start_i = 1'b1;
        @(negedge clk);
        fs_i = 64'h3F800000; ft_i = 64'h3F800000; fr_i = 64'h0;
        chk("R9 busy no done 1", 64'(done_o), 64'd0);
        @(negedge clk);
        chk("R9 busy no done 2", 64'(done_o), 64'd0);
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 busy done", 64'(done_o), 64'd1);
        expect_out("R9 busy first op", 64'h40E00000, 5'h00);
        seen = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (done_o) seen++;
        end
        chk("R9 busy start ignored", 64'(seen), 64'd0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_basic;
        t_round;
        t_overflow;
        t_tiny;
        t_invalid;
        t_zero_sign;
        t_paired;
        t_unimpl;
        t_trap;
        t_busy;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule